// File: doc/BRIEF.md
# Register-Transfer Fetch-Execute Controller

This block is a small multi-cycle processor control unit. Every memory reference goes through an explicit address register and data register in a fixed order, and that includes the fetch of the next instruction. No combinational path runs from the program counter to the memory address. The block keeps a program counter, a current instruction register and an accumulator. It steps through fetch, decode and execute over and over until it decodes a halt.

The address bus only leaves the block. A read strobe and a write strobe sit beside it. A split data-in and data-out pair takes the place of a two-way data bus. Memory is assumed to be synchronous, with one cycle of read latency. Each instruction is a single 16-bit word. The operation code occupies the top four bits and the operand address occupies the lower twelve.

Top module: `rtf_ctrl`

## Requirements
- R1: While rst_n is low at a rising clock edge, the block clears all of its registers to zero and enters the fetch state. Both strobes read low, halted reads low and mem_addr reads zero. The first fetch after reset reads address 0.
- R2: For every instruction fetch, mem_addr holds the current program counter value, loaded through the address register, while mem_rd is high and mem_wr is low.
- R3: Each fetch advances the program counter by exactly one. Without a branch, consecutive fetches read consecutive addresses.
- R4: The returned word is captured in the data register one cycle after the read strobe and is copied to the instruction register on the following cycle. A load or add therefore issues its operand read exactly 4 cycles after its fetch read.
- R5: Bits 15:12 of the instruction hold the operation code and bits 11:0 hold the operand address. The codes are 0 halt, 1 load, 2 store, 3 add and 4 branch. Every other code is a no-operation: it makes no memory access, and the next fetch read comes 5 cycles after its own fetch read.
- R6: Load puts the word read from the operand address into the accumulator. Add sums that word into the accumulator modulo 2^16. The operand read arrives after the cycle in which the previous access ended, and the next fetch read comes 4 cycles after the operand read.
- R7: Store drives the operand address on mem_addr and the accumulator on mem_wdata. It raises mem_wr for exactly one cycle, 5 cycles after its fetch read, and the next fetch read follows 2 cycles later.
- R8: Branch makes the next fetch read the operand address instead of the incremented one, 6 cycles after the branch's own fetch read.
- R9: After a halt is decoded, halted goes high and stays high until reset, and neither strobe rises again.
- R10: mem_rd and mem_wr are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| mem_addr | output | ADDR_W (12) | Address bus, driven from the address register |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | DATA_W (16) | Data out, driven from the data register |
| mem_rdata | input | DATA_W (16) | Data in, valid one cycle after mem_rd |
| halted | output | 1 | High once a halt has executed |

## Verification
The bench builds the block with its default parameters: a 16-bit word, a 4-bit operation code and a 12-bit address. With these values an add whose sum overflows 16 bits can show the wrap-around, and operand and branch addresses fall inside a small memory model that the bench owns. The scoreboard expects every strobe event in order, with its address, its write data and its cycle distance from the previous event. This makes the fixed transfer sequence of each instruction kind visible at the pins. The bench also checks quiet behaviour after halt and that reset releases the halted state.

// File: rtl/rtf_pkg.sv
// Package: shared widths, operation codes, sequencer states and the
// control-word type passed from the sequencer to the datapath.
// Assumes a single-word instruction with the opcode in the top bits.
package rtf_pkg;
    localparam int DATA_W = 16;
    localparam int OPC_W  = 4;
    localparam int ADDR_W = DATA_W - OPC_W;

    localparam logic [OPC_W-1:0] OP_HALT  = 4'd0;
    localparam logic [OPC_W-1:0] OP_LOAD  = 4'd1;
    localparam logic [OPC_W-1:0] OP_STORE = 4'd2;
    localparam logic [OPC_W-1:0] OP_ADD   = 4'd3;
    localparam logic [OPC_W-1:0] OP_BRA   = 4'd4;

    typedef enum logic [3:0] {
        S_FADDR, S_FREAD, S_FCAP, S_FIR, S_DEC,
        S_XRD, S_XCAP, S_XALU, S_XST, S_XWR, S_XBR, S_HALT
    } seq_state_t;

    typedef struct packed {
        logic mar_from_pc;
        logic mar_from_opnd;
        logic rd;
        logic wr;
        logic pc_inc;
        logic pc_from_opnd;
        logic mdr_from_mem;
        logic mdr_from_acc;
        logic cir_from_mdr;
        logic acc_load;
        logic acc_add;
    } ctl_t;
endpackage

// File: rtl/rtf_acc_alu.sv
// Module: accumulator operand selector and adder.
// Returns either the data register value (load) or the sum of the
// accumulator and data register, which wraps at W bits (add).
// Assumes the caller decides when the result is written back.
module rtf_acc_alu #(
    parameter int W = 16
) (
    input  logic         add_en,
    input  logic [W-1:0] acc,
    input  logic [W-1:0] mdr,
    output logic [W-1:0] result
);
    // Pick the pass-through or the modular sum.
    always_comb begin
        if (add_en) result = acc + mdr;
        else        result = mdr;
    end
endmodule

// File: rtl/rtf_seq.sv
// Module: fetch/decode/execute sequencer.
// Walks one state per register transfer and emits a control word.
// Assumes the opcode input reflects the instruction register, which
// the datapath loads at the end of the S_FIR state.
module rtf_seq
    import rtf_pkg::*;
#(
    parameter int OW = OPC_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [OW-1:0] opcode,
    output ctl_t          ctl,
    output logic          halted
);
    seq_state_t st, st_nx;

    // State register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) st <= S_FADDR;
        else        st <= st_nx;
    end

    // Next-state selection and control word for each transfer step.
    always_comb begin
        ctl   = '0;
        st_nx = st;
        unique case (st)
            S_FADDR: begin ctl.mar_from_pc = 1'b1; st_nx = S_FREAD; end
            S_FREAD: begin ctl.rd = 1'b1; ctl.pc_inc = 1'b1; st_nx = S_FCAP; end
            S_FCAP:  begin ctl.mdr_from_mem = 1'b1; st_nx = S_FIR; end
            S_FIR:   begin ctl.cir_from_mdr = 1'b1; st_nx = S_DEC; end
            S_DEC: begin
                if (opcode == OP_HALT) begin
                    st_nx = S_HALT;
                end else if (opcode == OP_LOAD || opcode == OP_ADD) begin
                    ctl.mar_from_opnd = 1'b1;
                    st_nx = S_XRD;
                end else if (opcode == OP_STORE) begin
                    ctl.mar_from_opnd = 1'b1;
                    st_nx = S_XST;
                end else if (opcode == OP_BRA) begin
                    st_nx = S_XBR;
                end else begin
                    st_nx = S_FADDR;
                end
            end
            S_XRD:   begin ctl.rd = 1'b1; st_nx = S_XCAP; end
            S_XCAP:  begin ctl.mdr_from_mem = 1'b1; st_nx = S_XALU; end
            S_XALU: begin
                ctl.acc_load = 1'b1;
                ctl.acc_add  = (opcode == OP_ADD);
                st_nx = S_FADDR;
            end
            S_XST:   begin ctl.mdr_from_acc = 1'b1; st_nx = S_XWR; end
            S_XWR:   begin ctl.wr = 1'b1; st_nx = S_FADDR; end
            S_XBR:   begin ctl.pc_from_opnd = 1'b1; st_nx = S_FADDR; end
            S_HALT:  st_nx = S_HALT;
            default: st_nx = S_FADDR;
        endcase
    end

    assign halted = (st == S_HALT);

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(ctl.rd && ctl.wr));                                   // R10
    AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted);                                     // R9
    AST_HALT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> (!ctl.rd && !ctl.wr));                       // R9
    AST_CAPTURE_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.rd |=> ctl.mdr_from_mem);                           // R4
endmodule

// File: rtl/rtf_datapath.sv
// Module: register file of the controller (PC, MAR, MDR, CIR, ACC).
// Every memory address comes from MAR and every written word from MDR.
// Assumes at most one load source per register is active in a cycle.
module rtf_datapath
    import rtf_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int OW = OPC_W,
    parameter int AW = DW - OW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  ctl_t          ctl,
    input  logic [DW-1:0] mem_rdata,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    output logic [OW-1:0] opcode
);
    logic [AW-1:0] pc, mar;
    logic [DW-1:0] mdr, cir, acc, alu_out;
    logic [AW-1:0] opnd;

    assign opnd   = cir[AW-1:0];
    assign opcode = cir[DW-1:AW];

    rtf_acc_alu #(.W(DW)) u_alu (
        .add_en (ctl.acc_add),
        .acc    (acc),
        .mdr    (mdr),
        .result (alu_out)
    );

    // Program counter: advance on fetch or take the branch target.
    always_ff @(posedge clk) begin
        if (!rst_n)                pc <= '0;
        else if (ctl.pc_from_opnd) pc <= opnd;
        else if (ctl.pc_inc)       pc <= pc + AW'(1);
    end

    // Address register: fed from the PC for fetch, the operand otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)                 mar <= '0;
        else if (ctl.mar_from_pc)   mar <= pc;
        else if (ctl.mar_from_opnd) mar <= opnd;
    end

    // Data register: memory word on capture, accumulator before a store.
    always_ff @(posedge clk) begin
        if (!rst_n)                mdr <= '0;
        else if (ctl.mdr_from_mem) mdr <= mem_rdata;
        else if (ctl.mdr_from_acc) mdr <= acc;
    end

    // Instruction register: only ever loaded from the data register.
    always_ff @(posedge clk) begin
        if (!rst_n)                cir <= '0;
        else if (ctl.cir_from_mdr) cir <= mdr;
    end

    // Accumulator: result of load or add.
    always_ff @(posedge clk) begin
        if (!rst_n)            acc <= '0;
        else if (ctl.acc_load) acc <= alu_out;
    end

    assign mem_addr  = mar;
    assign mem_wdata = mdr;

    AST_FETCH_ADDR_PC: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.pc_inc |-> (ctl.rd && mar == pc));                  // R2
    AST_PC_INC: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.pc_inc |=> (pc == $past(pc) + AW'(1)));             // R3
    AST_CIR_FROM_MDR: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.cir_from_mdr |=> (cir == $past(mdr)));              // R4
    AST_WDATA_ACC: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.wr |-> (mem_wdata == acc));                         // R7
    AST_BRANCH_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.pc_from_opnd |=> (pc == $past(opnd)));              // R8
endmodule

// File: rtl/rtf_ctrl.sv
// Module: top of the register-transfer fetch-execute controller.
// Joins the sequencer and the datapath and exposes the memory pins.
// Assumes synchronous memory with one cycle of read latency.
module rtf_ctrl
    import rtf_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int OW = OPC_W,
    parameter int AW = DW - OW
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [AW-1:0] mem_addr,
    output logic          mem_rd,
    output logic          mem_wr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    output logic          halted
);
    ctl_t          ctl;
    logic [OW-1:0] opcode;

    rtf_seq #(.OW(OW)) u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .opcode (opcode),
        .ctl    (ctl),
        .halted (halted)
    );

    rtf_datapath #(.DW(DW), .OW(OW), .AW(AW)) u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl       (ctl),
        .mem_rdata (mem_rdata),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .opcode    (opcode)
    );

    assign mem_rd = ctl.rd;
    assign mem_wr = ctl.wr;
endmodule

// File: tb/rtf_ctrl_tb.sv
// Scoreboard bench: the driver pushes expected strobe events; a monitor
// pops and compares them (address, data, cycle gap) as they appear.
module rtf_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] mem_addr;
    logic        mem_rd, mem_wr, halted;
    logic [15:0] mem_wdata;
    logic [15:0] mem_rdata = '0;
    logic [15:0] mem [0:255];

    int tests = 0;
    int fails = 0;
    int cyc = 0;
    int last_cyc = -1;

    typedef struct {
        bit          wr;
        logic [11:0] addr;
        logic [15:0] data;
        int          gap;
        string       req;
    } ev_t;
    ev_t sb[$];

    always #5 clk = ~clk;

    rtf_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_rd(mem_rd),
        .mem_wr(mem_wr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .halted(halted)
    );

    // Synchronous memory model, one cycle read latency.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (mem_wr) mem[mem_addr[7:0]] <= mem_wdata;
        if (mem_rd) mem_rdata <= mem[mem_addr[7:0]];
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic push(input bit wr, input logic [11:0] a, input logic [15:0] d,
                        input int gap, input string req);
        ev_t e;
        e.wr = wr; e.addr = a; e.data = d; e.gap = gap; e.req = req;
        sb.push_back(e);
    endtask

    // Monitor: compare each strobe event against the scoreboard head.
    always @(negedge clk) begin
        if (rst_n && (mem_rd || mem_wr)) begin
            chk(!(mem_rd && mem_wr), "R10", "rd and wr together", 1, 0);
            if (sb.size() == 0) begin
                chk(1'b0, "R9", "unexpected access addr", int'(mem_addr), 0);
            end else begin
                ev_t e;
                e = sb.pop_front();
                chk(mem_wr == e.wr, e.req, "strobe kind wr", int'(mem_wr), int'(e.wr));
                chk(mem_addr == e.addr, e.req, "address", int'(mem_addr), int'(e.addr));
                if (e.wr)
                    chk(mem_wdata == e.data, e.req, "write data", int'(mem_wdata), int'(e.data));
                if (e.gap >= 0)
                    chk(cyc - last_cyc == e.gap, e.req, "cycle gap", cyc - last_cyc, e.gap);
            end
            last_cyc = cyc;
        end
    end

    task automatic clear_mem();
        for (int i = 0; i < 256; i++) mem[i] = 16'h0000;
    endtask

    task automatic run_to_halt();
        int n;
        n = 0;
        @(negedge clk);
        rst_n = 1'b1;
        last_cyc = -1;
        while (!halted && n < 1000) begin
            @(negedge clk);
            n++;
        end
        chk(halted == 1'b1, "R9", "halted after program", int'(halted), 1);
        chk(sb.size() == 0, "R9", "events left in scoreboard", sb.size(), 0);
        // Quiet window: monitor flags any access; halted must stay high.
        repeat (20) @(negedge clk);
        chk(halted == 1'b1, "R9", "halted sticky", int'(halted), 1);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired: actual running expected finished");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        // Program 1: load, wrapping add, store, branch over a store, no-op, store, halt.
        clear_mem();
        mem[0] = 16'h1040;  // load 0x40
        mem[1] = 16'h3041;  // add 0x41
        mem[2] = 16'h2050;  // store 0x50
        mem[3] = 16'h4006;  // branch 6
        mem[4] = 16'h2051;  // skipped store
        mem[5] = 16'h0000;  // skipped halt
        mem[6] = 16'hF000;  // no-op
        mem[7] = 16'h2052;  // store 0x52
        mem[8] = 16'h0000;  // halt
        mem[8'h40] = 16'h8001;
        mem[8'h41] = 16'h9000;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(mem_rd == 1'b0, "R1", "rd in reset", int'(mem_rd), 0);
        chk(mem_wr == 1'b0, "R1", "wr in reset", int'(mem_wr), 0);
        chk(halted == 1'b0, "R1", "halted in reset", int'(halted), 0);
        chk(mem_addr == 12'h000, "R1", "addr in reset", int'(mem_addr), 0);

        push(0, 12'h000, 16'h0, -1, "R1");
        push(0, 12'h040, 16'h0, 4, "R4");
        push(0, 12'h001, 16'h0, 4, "R3");
        push(0, 12'h041, 16'h0, 4, "R6");
        push(0, 12'h002, 16'h0, 4, "R2");
        push(1, 12'h050, 16'h1001, 5, "R7");
        push(0, 12'h003, 16'h0, 2, "R7");
        push(0, 12'h006, 16'h0, 6, "R8");
        push(0, 12'h007, 16'h0, 5, "R5");
        push(1, 12'h052, 16'h1001, 5, "R6");
        push(0, 12'h008, 16'h0, 2, "R3");
        run_to_halt();
        chk(mem[8'h50] == 16'h1001, "R6", "wrapped sum stored", int'(mem[8'h50]), 16'h1001);
        chk(mem[8'h51] == 16'h0000, "R8", "skipped store untouched", int'(mem[8'h51]), 0);

        // Reset releases halted and restarts at address 0.
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk(halted == 1'b0, "R1", "halted cleared by reset", int'(halted), 0);
        chk(mem_addr == 12'h000, "R1", "addr cleared by reset", int'(mem_addr), 0);

        // Program 2: load, add to itself, store, halt.
        clear_mem();
        mem[0] = 16'h1020;
        mem[1] = 16'h3020;
        mem[2] = 16'h2021;
        mem[3] = 16'h0000;
        mem[8'h20] = 16'h0123;
        push(0, 12'h000, 16'h0, -1, "R1");
        push(0, 12'h020, 16'h0, 4, "R4");
        push(0, 12'h001, 16'h0, 4, "R6");
        push(0, 12'h020, 16'h0, 4, "R6");
        push(0, 12'h002, 16'h0, 4, "R3");
        push(1, 12'h021, 16'h0246, 5, "R7");
        push(0, 12'h003, 16'h0, 2, "R5");
        run_to_halt();
        chk(mem[8'h21] == 16'h0246, "R6", "doubled value stored", int'(mem[8'h21]), 16'h0246);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule